// File: doc/BRIEF.md
# Five-Pin Bidirectional Port with Pad Mode Control

This block is a small bus-mapped I/O port with five pins. Software programs three registers: a latched output value, a per-pin direction, and a per-pin pull-up enable. The direction register also holds a single bit that selects slow output edges on every pin driver. For each pin, the direction bit and the pull-up bit together pick one of four pad modes: plain input, input with pull-up, push-pull output, or open-drain output with pull-up. The block drives a pad model with a per-pin output enable, drive value, pull-up enable and slew select.

Two pins, pin 3 and pin 4, can be used as analog channels. When a channel is selected and the converter-enable input is high, the block forces that pin to input mode and turns its pull-up off. The stored direction bit is not changed. When the override ends, the pin returns to its programmed mode. Pin inputs pass through a two-stage synchronizer. The synchronized value of pin 0 feeds a timer capture line, which is held low while pin 0 is an output.

Top module: `bidir_port_ctrl`

## Requirements
- R1: While reset is low, and right after it, direction, pull-up and slow-edge state are zero: `pad_oe`, `pad_pu` and `pad_slow` are all 0, and a read of the direction register returns 0.
- R2: Reset does not change the output data latch. `pad_do` shows the latched data of any pin that is not in open-drain mode, so the latched value can be seen there after a reset.
- R3: A write with `wr_en` high at address 0x01, 0x05 or 0x11 updates the data, direction or pull-up register on the next rising clock edge. Reads are combinational from `addr`. The direction register reads as {0, slow, 0, dir[4:0]}, with the slow-edge bit at bit 6. The pull-up register reads as {000, pu[4:0]}.
- R4: Push-pull output mode (direction 1, pull-up 0): `pad_oe`=1, `pad_do` equals the data bit, and `pad_pu`=0.
- R5: Input modes (effective direction 0): `pad_oe`=0, and `pad_pu` equals the effective pull-up bit.
- R6: Open-drain mode (direction 1, pull-up 1): `pad_pu`=1 and `pad_do`=0. `pad_oe` is the inverse of the data bit, so the pad is driven low only when the data bit is 0. The pad never drives high while its pull-up is on.
- R7: Every bit of `pad_slow` equals direction-register bit 6.
- R8: When `conv_en` is 1, `ana_sel[0]` forces pin 3, and `ana_sel[1]` forces pin 4, to `pad_oe`=0 and `pad_pu`=0. The direction register read is unchanged. The programmed mode comes back once the override is removed.
- R9: A read at 0x01 returns, for each pin, the latched data bit if the pin is an effective output. For an input pin it returns the pin level sampled two rising edges earlier. Bits 7..5 read 0.
- R10: `cap_out` equals the synchronized level of pin 0 while pin 0 is an effective input, and is 0 while pin 0 is an output.
- R11: A write to any other address changes no register, and any address other than the three registers reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 8 | Register address for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| pin_in | input | 5 | Raw pad input levels |
| ana_sel | input | 2 | Analog select for pin 3 (bit 0) and pin 4 (bit 1) |
| conv_en | input | 1 | Converter enable that gates the analog override |
| pad_oe | output | 5 | Per-pin output enable |
| pad_do | output | 5 | Per-pin drive value |
| pad_pu | output | 5 | Per-pin pull-up enable |
| pad_slow | output | 5 | Per-pin slow-edge select |
| cap_out | output | 1 | Timer capture signal from pin 0 |

## Verification
The assertions assume that every input is a known value at each rising edge. They also assume that the analog select and converter enable reach the pads only through the override gating, with no other path to the pad pins. No assertion makes a claim about the synchronizer's settle time across a reset release, because the raw pin level and the synchronized level can differ just after reset. The stimulus changes all inputs only half a period after the rising edge. It mixes writes to the three register addresses with writes to other addresses, and it toggles the analog controls while pins 3 and 4 are in each of the four modes. The output latch is written before any check depends on its value, because reset leaves the latch undefined.

// File: rtl/bidir_port_pkg.sv
package bidir_port_pkg;

  // Pad mode, encoded as {direction, pull-up}
  typedef enum logic [1:0] {
    PM_IN        = 2'b00,
    PM_IN_PULL   = 2'b01,
    PM_PUSHPULL  = 2'b10,
    PM_OPENDRAIN = 2'b11
  } pad_mode_e;

  typedef struct packed {
    logic oe;
    logic dout;
    logic pull;
  } pad_ctl_t;

  function automatic pad_mode_e mode_of(input logic dir_bit, input logic pull_bit);
    return pad_mode_e'({dir_bit, pull_bit});
  endfunction

  function automatic pad_ctl_t ctl_of(input pad_mode_e mode, input logic data_bit);
    pad_ctl_t c;
    case (mode)
      PM_IN:        c = '{oe: 1'b0,      dout: data_bit, pull: 1'b0};
      PM_IN_PULL:   c = '{oe: 1'b0,      dout: data_bit, pull: 1'b1};
      PM_PUSHPULL:  c = '{oe: 1'b1,      dout: data_bit, pull: 1'b0};
      default:      c = '{oe: ~data_bit, dout: 1'b0,     pull: 1'b1};
    endcase
    return c;
  endfunction

  // Read merge: output pins show the latch, input pins show the synced level
  function automatic logic pin_read(input logic eff_dir, input logic latch_bit,
                                    input logic sync_bit);
    return eff_dir ? latch_bit : sync_bit;
  endfunction

endpackage

// File: rtl/bidir_port_regs.sv
module bidir_port_regs #(
  parameter int NPINS     = 5,
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter logic [AW-1:0] ADDR_DATA = 8'h01,
  parameter logic [AW-1:0] ADDR_DIR  = 8'h05,
  parameter logic [AW-1:0] ADDR_PULL = 8'h11,
  parameter int SLEW_BIT  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [NPINS-1:0] data_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] pu_q,
  output logic             slow_q
);

  logic wr_data, wr_dir, wr_pull;
  logic wdata_unused;

  assign wr_data = wr_en && (addr == ADDR_DATA);
  assign wr_dir  = wr_en && (addr == ADDR_DIR);
  assign wr_pull = wr_en && (addr == ADDR_PULL);
  assign wdata_unused = ^wdata;

  // Output latch is deliberately left out of reset
  always_ff @(posedge clk) begin
    if (wr_data) data_q <= wdata[NPINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      pu_q   <= '0;
      slow_q <= 1'b0;
    end else begin
      if (wr_dir) begin
        dir_q  <= wdata[NPINS-1:0];
        slow_q <= wdata[SLEW_BIT];
      end
      if (wr_pull) pu_q <= wdata[NPINS-1:0];
    end
  end

endmodule

// File: rtl/bidir_port_sync.sv
module bidir_port_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/bidir_port_pad.sv
module bidir_port_pad
  import bidir_port_pkg::*;
(
  input  logic dir_bit,
  input  logic pull_bit,
  input  logic data_bit,
  input  logic ovr,
  output logic eff_dir,
  output logic oe,
  output logic dout,
  output logic pull
);

  logic      eff_pull;
  pad_mode_e mode;
  pad_ctl_t  ctl;

  // Override forces input without pull-up; stored bits are untouched
  assign eff_dir  = dir_bit  & ~ovr;
  assign eff_pull = pull_bit & ~ovr;
  assign mode     = mode_of(eff_dir, eff_pull);
  assign ctl      = ctl_of(mode, data_bit);

  assign oe   = ctl.oe;
  assign dout = ctl.dout;
  assign pull = ctl.pull;

endmodule

// File: rtl/bidir_port_ctrl.sv
module bidir_port_ctrl
  import bidir_port_pkg::*;
#(
  parameter int NPINS     = 5,
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter logic [AW-1:0] ADDR_DATA = 8'h01,
  parameter logic [AW-1:0] ADDR_DIR  = 8'h05,
  parameter logic [AW-1:0] ADDR_PULL = 8'h11,
  parameter int SLEW_BIT  = 6,
  parameter int ANA_BASE  = 3,
  parameter int ANA_CNT   = 2,
  parameter int CAP_PIN   = 0,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NPINS-1:0] pin_in,
  input  logic [ANA_CNT-1:0] ana_sel,
  input  logic             conv_en,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_do,
  output logic [NPINS-1:0] pad_pu,
  output logic [NPINS-1:0] pad_slow,
  output logic             cap_out
);

  localparam int ANA_TOP = ANA_BASE + ANA_CNT;

  logic [NPINS-1:0] data_q, dir_q, pu_q;
  logic             slow_q;
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] ovr;
  logic [NPINS-1:0] eff_dir;

  bidir_port_regs #(
    .NPINS(NPINS), .AW(AW), .DW(DW),
    .ADDR_DATA(ADDR_DATA), .ADDR_DIR(ADDR_DIR), .ADDR_PULL(ADDR_PULL),
    .SLEW_BIT(SLEW_BIT)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .data_q(data_q), .dir_q(dir_q), .pu_q(pu_q), .slow_q(slow_q)
  );

  bidir_port_sync #(.W(NPINS), .STAGES(SYNC_STG)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    if (i >= ANA_BASE && i < ANA_TOP) begin : g_ana
      assign ovr[i] = conv_en & ana_sel[i-ANA_BASE];
    end else begin : g_dig
      assign ovr[i] = 1'b0;
    end

    bidir_port_pad pad_i (
      .dir_bit(dir_q[i]), .pull_bit(pu_q[i]), .data_bit(data_q[i]), .ovr(ovr[i]),
      .eff_dir(eff_dir[i]), .oe(pad_oe[i]), .dout(pad_do[i]), .pull(pad_pu[i])
    );

    assign pad_slow[i] = slow_q;
  end

  assign cap_out = ~eff_dir[CAP_PIN] & pin_sync[CAP_PIN];

  always_comb begin
    rdata = '0;
    if (addr == ADDR_DATA) begin
      for (int i = 0; i < NPINS; i++)
        rdata[i] = pin_read(eff_dir[i], data_q[i], pin_sync[i]);
    end else if (addr == ADDR_DIR) begin
      rdata[NPINS-1:0] = dir_q;
      rdata[SLEW_BIT]  = slow_q;
    end else if (addr == ADDR_PULL) begin
      rdata[NPINS-1:0] = pu_q;
    end
  end

endmodule

// File: rtl/bidir_port_chk.sv
module bidir_port_chk #(
  parameter int NPINS     = 5,
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter logic [AW-1:0] ADDR_DATA = 8'h01,
  parameter logic [AW-1:0] ADDR_DIR  = 8'h05,
  parameter logic [AW-1:0] ADDR_PULL = 8'h11,
  parameter int SLEW_BIT  = 6,
  parameter int ANA_BASE  = 3,
  parameter int ANA_CNT   = 2,
  parameter int CAP_PIN   = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    rdata,
  input logic [ANA_CNT-1:0] ana_sel,
  input logic             conv_en,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_do,
  input logic [NPINS-1:0] pad_pu,
  input logic [NPINS-1:0] pad_slow,
  input logic             cap_out,
  input logic [NPINS-1:0] eff_dir,
  input logic [NPINS-1:0] data_q,
  input logic [NPINS-1:0] dir_q,
  input logic [NPINS-1:0] pu_q,
  input logic             slow_q
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) rst_quiet_chk: assert (pad_oe == '0 && pad_pu == '0 && pad_slow == '0);
  end

  // R6
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu & pad_do) == '0);

  // R7
  slow_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_slow == '0) || (pad_slow == '1));

  // R10
  cap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eff_dir[CAP_PIN] |-> !cap_out);

  // R3
  dir_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_DIR) |-> (rdata[DW-1] == 1'b0 && rdata[SLEW_BIT-1] == 1'b0));

  // R11
  stray_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != ADDR_DATA && addr != ADDR_DIR && addr != ADDR_PULL)
    |=> ($stable(dir_q) && $stable(pu_q) && $stable(slow_q) && $stable(data_q)));

  for (genvar k = 0; k < ANA_CNT; k++) begin : g_ana_chk
    // R8
    ana_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_en && ana_sel[k]) |-> (!pad_oe[ANA_BASE+k] && !pad_pu[ANA_BASE+k]));
  end

endmodule

bind bidir_port_ctrl bidir_port_chk #(
  .NPINS(NPINS), .AW(AW), .DW(DW),
  .ADDR_DATA(ADDR_DATA), .ADDR_DIR(ADDR_DIR), .ADDR_PULL(ADDR_PULL),
  .SLEW_BIT(SLEW_BIT), .ANA_BASE(ANA_BASE), .ANA_CNT(ANA_CNT), .CAP_PIN(CAP_PIN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .ana_sel(ana_sel), .conv_en(conv_en), .pad_oe(pad_oe), .pad_do(pad_do),
  .pad_pu(pad_pu), .pad_slow(pad_slow), .cap_out(cap_out), .eff_dir(eff_dir),
  .data_q(data_q), .dir_q(dir_q), .pu_q(pu_q), .slow_q(slow_q)
);

// File: tb/bidir_port_ctrl_tb.sv
module bidir_port_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [4:0] pin_in = 5'h00;
  logic [1:0] ana_sel = 2'b00;
  logic       conv_en = 1'b0;
  logic [4:0] pad_oe, pad_do, pad_pu, pad_slow;
  logic       cap_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  bidir_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .ana_sel(ana_sel), .conv_en(conv_en),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu), .pad_slow(pad_slow),
    .cap_out(cap_out)
  );

  // Behavioural reference state
  bit [4:0] m_data, m_dir, m_pu;
  bit       m_slow;
  bit       data_known = 1'b0;
  bit [4:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir  <= 5'h0;
      m_pu   <= 5'h0;
      m_slow <= 1'b0;
      hist.delete();
    end else begin
      if (wr_en && addr == 8'h01) begin m_data <= wdata[4:0]; data_known <= 1'b1; end
      if (wr_en && addr == 8'h05) begin m_dir <= wdata[4:0]; m_slow <= wdata[6]; end
      if (wr_en && addr == 8'h11) m_pu <= wdata[4:0];
      hist.push_front(pin_in);
      if (hist.size() > 2) void'(hist.pop_back());
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog R1: cycles %0d expected below %0d", cyc, 50000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic check_all();
    bit [4:0] e_oe, e_do, e_pu, e_ed, syncv;
    bit [7:0] e_rd;
    syncv = (hist.size() >= 2) ? hist[1] : 5'h0;
    for (int i = 0; i < 5; i++) begin
      bit ov, ed, ep;
      ov = conv_en && ((i == 3 && ana_sel[0]) || (i == 4 && ana_sel[1]));
      ed = m_dir[i] && !ov;
      ep = m_pu[i] && !ov;
      e_ed[i] = ed;
      if (!ed) begin e_oe[i] = 0; e_do[i] = m_data[i]; e_pu[i] = ep; end
      else if (!ep) begin e_oe[i] = 1; e_do[i] = m_data[i]; e_pu[i] = 0; end
      else begin e_oe[i] = !m_data[i]; e_do[i] = 0; e_pu[i] = 1; end
    end
    case (addr)
      8'h01: for (int i = 0; i < 5; i++) e_rd[i] = e_ed[i] ? m_data[i] : syncv[i];
      8'h05: e_rd = {1'b0, m_slow, 1'b0, m_dir};
      8'h11: e_rd = {3'b000, m_pu};
      default: e_rd = 8'h00;
    endcase
    if (addr == 8'h01) e_rd[7:5] = 3'b000;
    chk("R4 R6 R8 pad_oe", {3'b0, pad_oe}, {3'b0, e_oe});
    chk("R5 R6 R8 pad_pu", {3'b0, pad_pu}, {3'b0, e_pu});
    chk("R7 pad_slow", {3'b0, pad_slow}, {3'b0, {5{m_slow}}});
    chk("R10 cap_out", {7'b0, cap_out}, {7'b0, (!e_ed[0]) && syncv[0]});
    if (data_known) begin
      chk("R2 R4 R6 pad_do", {3'b0, pad_do}, {3'b0, e_do});
      chk("R3 R9 R11 rdata", rdata, e_rd);
    end else if (addr != 8'h01) begin
      chk("R3 R11 rdata", rdata, e_rd);
    end
  endtask

  task automatic tick(input logic we, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d;
    #2 check_all();
  endtask

  initial begin
    // R1: reset state
    tick(0, 8'h05, 8'h00);
    chk("R1 reset dir read", rdata, 8'h00);
    chk("R1 reset oe/pu", {3'b0, pad_oe | pad_pu}, 8'h00);
    tick(0, 8'h11, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    tick(1, 8'h01, 8'h16);
    // Push-pull / open-drain / inputs: dir=11010, pu=10100
    tick(1, 8'h05, 8'h5A);
    tick(1, 8'h11, 8'h14);
    tick(0, 8'h05, 8'h00);
    tick(0, 8'h01, 8'h00);
    pin_in = 5'h15;
    for (int k = 0; k < 4; k++) tick(0, 8'h01, 8'h00);
    // R8: analog override on pins 3 and 4, then released
    conv_en = 1'b1; ana_sel = 2'b11;
    tick(0, 8'h05, 8'h00);
    chk("R8 dir kept", rdata, 8'h5A);
    ana_sel = 2'b01; tick(0, 8'h01, 8'h00);
    conv_en = 1'b0; tick(0, 8'h01, 8'h00);
    // R10: pin 0 as input vs output
    tick(1, 8'h05, 8'h00);
    pin_in = 5'h01;
    for (int k = 0; k < 3; k++) tick(0, 8'h01, 8'h00);
    chk("R10 cap follows pin0", {7'b0, cap_out}, 8'h01);
    tick(1, 8'h05, 8'h01);
    tick(0, 8'h01, 8'h00);
    chk("R10 cap held low", {7'b0, cap_out}, 8'h00);
    // R11: stray write
    tick(1, 8'h07, 8'hFF);
    tick(0, 8'h05, 8'h00);
    chk("R11 stray write ignored", rdata, 8'h01);
    // Random mix
    for (int n = 0; n < 3000; n++) begin
      bit [7:0] a;
      int sel = $urandom_range(0, 3);
      a = (sel == 0) ? 8'h01 : (sel == 1) ? 8'h05 : (sel == 2) ? 8'h11 : 8'($urandom);
      if ($urandom_range(0, 3) == 0) pin_in = 5'($urandom);
      if ($urandom_range(0, 9) == 0) begin ana_sel = 2'($urandom); conv_en = 1'($urandom); end
      tick($urandom_range(0, 2) == 0, a, 8'($urandom));
    end
    // R2: latch survives reset
    conv_en = 1'b0;
    tick(1, 8'h01, 8'h0B);
    tick(1, 8'h05, 8'h00);
    @(negedge clk); rst_n = 1'b0;
    tick(0, 8'h05, 8'h00);
    chk("R2 latch kept over reset", {3'b0, pad_do}, 8'h0B);
    chk("R1 dir cleared", rdata, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 4; k++) tick(0, 8'h01, 8'h00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule